// File: doc/BRIEF.md
# Zero-Crossing Gated Gain Updater

This block decides, for each audio channel on its own, when a newly requested 8-bit gain code replaces the code that drives the analog tap selection. A serial front end hands it a requested code and a one-cycle strobe per channel. A detector upstream supplies a one-cycle zero-crossing pulse per channel. Three global controls complete the inputs: a crossing enable, an active-low mute pin and an active-low chip select. The block outputs the code now in force on each channel and a flag that marks the channel as muted.

Each channel runs an independent state machine with three states. IDLE compares the wanted code with the active one. On a mismatch it takes the transition "load" to PENDING when gating applies, or the transition "direct" to APPLY. PENDING waits for crossings or for the timeout. A newer request in PENDING takes "restart", which stays in PENDING, "cancel", which returns to IDLE when the wanted code equals the active code again, or "direct", which goes to APPLY when gating no longer applies. When enough crossings arrive, PENDING takes "crossed" to APPLY. When the timeout expires, it takes "expire" to APPLY. APPLY copies the pending code to the output and always takes "done" back to IDLE.

The wanted code is 0x00 while the effective mute is active, and otherwise the last requested code. The timeout length is computed from the system clock frequency parameter and a timeout in milliseconds, 16 ms by default.

Top module: `zc_gain_updater`

## Requirements
- R1: With the crossing enable low and no mute engaged, a requested code appears on that channel's gain output at the second rising clock edge after the edge that samples its strobe.
- R2: With the crossing enable high, a changed code is held back until two crossing pulses have been sampled on that same channel while the update is pending. Pulses on the other channel do not count.
- R3: When no second crossing arrives, the pending code is applied anyway once TO_CYC = CLK_HZ/1000*TIMEOUT_MS cycles have passed in PENDING. This places the new code on the output TO_CYC+2 edges after the strobe edge.
- R4: A newer request that arrives while an update is pending restarts the timeout and clears the crossings counted so far.
- R5: Code 0x00 is the mute code, which routes the input to ground. Codes 1 to 255 select a gain of 31.5 - 0.5*(255-N) dB. The muted flag of a channel is high exactly when its output code is 0x00. Channel c uses bits [8c+7:8c] of the code buses.
- R6: While the mute pin is engaged (low), each channel moves to code 0x00 after its own next single crossing or after the timeout. This happens whatever the state of the crossing enable.
- R7: The mute pin level is taken in only while chip select is high. A mute asserted while chip select is low has no effect until chip select returns high.
- R8: After reset both channels output 0x00 with the muted flag set. Each channel updates independently of the others.
- R9: Releasing the mute pin restores the programmed codes under the normal rules. With the crossing enable low, the codes return at once.
- R10: The output code changes only in the cycle that follows the APPLY state. IDLE never moves straight to APPLY while the mute is in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_code | input | NCH*CODE_W | Requested code per channel |
| req_stb | input | NCH | One-cycle strobe per channel that loads its requested code |
| zc_evt | input | NCH | One-cycle zero-crossing pulse per channel |
| zc_en | input | 1 | Crossing enable; high gates gain changes |
| mute_n | input | 1 | Mute pin, active low |
| cs_n | input | 1 | Serial chip select, active low |
| gain_code | output | NCH*CODE_W | Code in force per channel |
| muted | output | NCH | High while the channel's code is 0x00 |

## Verification
A channel stuck in PENDING shows as an old code that outlasts the timeout. A crossing counter that is not cleared applies a code after a single crossing. Both faults become visible within one timeout window plus two cycles of the request. A mute latch that ignores chip select mutes a channel during a transfer, at the first crossing after the pin falls. A state machine that bypasses gating changes the code two cycles after a strobe, before any crossing. The directed cases place crossings and requests exactly on these windows, and the seeded random phase varies the crossing count and the enable on every request.

// File: rtl/zcg_pkg.sv
package zcg_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_PEND  = 2'd1,
        S_APPLY = 2'd2
    } zcg_state_e;

    // Crossings that release a pending update: one for a pin mute, two otherwise.
    function automatic logic [1:0] crossings_needed(input logic pin_mute);
        return pin_mute ? 2'd1 : 2'd2;
    endfunction
endpackage

// File: rtl/zcg_mute_gate.sv
module zcg_mute_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic mute_n,
    input  logic cs_n,
    output logic mute_eff
);
    // Pin level only taken while no serial transfer is running.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mute_eff <= 1'b0;
        else if (cs_n)
            mute_eff <= ~mute_n;
    end
endmodule

// File: rtl/zcg_timeout.sv
module zcg_timeout #(
    parameter int TO_CYC = 16000,
    parameter int TW     = $clog2(TO_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [TW-1:0] cnt,
    output logic          expired
);
    localparam logic [TW-1:0] LAST = TW'(TO_CYC - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == LAST);
endmodule

// File: rtl/zcg_chan_fsm.sv
module zcg_chan_fsm
    import zcg_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] req_code,
    input  logic          req_stb,
    input  logic          zc_evt,
    input  logic          zc_en,
    input  logic          mute_act,
    input  logic          expired,
    output logic          tmr_clr,
    output zcg_state_e    st_o,
    output logic [CW-1:0] gain,
    output logic          muted
);
    zcg_state_e    st, st_nxt;
    logic [CW-1:0] tgt, pend, active, desired;
    logic [1:0]    zcnt, need;
    logic          ld_pend, clr_z, inc_z, gated;
    logic [2:0]    zc_next;

    assign desired = mute_act ? '0 : tgt;
    assign need    = crossings_needed(mute_act);
    assign gated   = mute_act | zc_en;
    assign zc_next = {1'b0, zcnt} + 3'd1;

    always_comb begin
        st_nxt  = st;
        ld_pend = 1'b0;
        clr_z   = 1'b0;
        inc_z   = 1'b0;
        tmr_clr = (st != S_PEND);
        unique case (st)
            S_IDLE: begin
                if (desired != active) begin
                    ld_pend = 1'b1;
                    clr_z   = 1'b1;
                    st_nxt  = gated ? S_PEND : S_APPLY;
                end
            end
            S_PEND: begin
                if (desired != pend) begin
                    tmr_clr = 1'b1;
                    clr_z   = 1'b1;
                    if (desired == active) begin
                        st_nxt = S_IDLE;
                    end else begin
                        ld_pend = 1'b1;
                        st_nxt  = gated ? S_PEND : S_APPLY;
                    end
                end else if (zc_evt && (zc_next >= {1'b0, need})) begin
                    st_nxt = S_APPLY;
                end else if (expired) begin
                    st_nxt = S_APPLY;
                end else if (zc_evt) begin
                    inc_z = 1'b1;
                end
            end
            S_APPLY: st_nxt = S_IDLE;
            default: st_nxt = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= S_IDLE;
        else
            st <= st_nxt;
    end

    // Data and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt    <= '0;
            pend   <= '0;
            zcnt   <= '0;
            active <= '0;
        end else begin
            if (req_stb)
                tgt <= req_code;
            if (ld_pend)
                pend <= desired;
            if (clr_z)
                zcnt <= '0;
            else if (inc_z)
                zcnt <= zcnt + 1'b1;
            if (st == S_APPLY)
                active <= pend;
        end
    end

    assign st_o  = st;
    assign gain  = active;
    assign muted = (active == '0);
endmodule

// File: rtl/zc_gain_updater.sv
module zc_gain_updater #(
    parameter int NCH        = 2,
    parameter int CODE_W     = 8,
    parameter int CLK_HZ     = 1_000_000,
    parameter int TIMEOUT_MS = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH*CODE_W-1:0]   req_code,
    input  logic [NCH-1:0]          req_stb,
    input  logic [NCH-1:0]          zc_evt,
    input  logic                    zc_en,
    input  logic                    mute_n,
    input  logic                    cs_n,
    output logic [NCH*CODE_W-1:0]   gain_code,
    output logic [NCH-1:0]          muted
);
    localparam int TO_CYC = (CLK_HZ / 1000) * TIMEOUT_MS;
    localparam int TMR_W  = $clog2(TO_CYC + 1);

    logic                       mute_eff;
    logic [NCH-1:0][1:0]        st_vec;
    logic [NCH-1:0][TMR_W-1:0]  tmr_vec;
    logic [NCH-1:0]             tclr_vec;
    logic [NCH-1:0]             exp_vec;

    zcg_mute_gate u_mute (
        .clk      (clk),
        .rst_n    (rst_n),
        .mute_n   (mute_n),
        .cs_n     (cs_n),
        .mute_eff (mute_eff)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        zcg_pkg::zcg_state_e st_c;

        zcg_timeout #(.TO_CYC(TO_CYC), .TW(TMR_W)) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (tclr_vec[c]),
            .cnt     (tmr_vec[c]),
            .expired (exp_vec[c])
        );

        zcg_chan_fsm #(.CW(CODE_W)) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_code (req_code[c*CODE_W +: CODE_W]),
            .req_stb  (req_stb[c]),
            .zc_evt   (zc_evt[c]),
            .zc_en    (zc_en),
            .mute_act (mute_eff),
            .expired  (exp_vec[c]),
            .tmr_clr  (tclr_vec[c]),
            .st_o     (st_c),
            .gain     (gain_code[c*CODE_W +: CODE_W]),
            .muted    (muted[c])
        );

        assign st_vec[c] = st_c;
    end
endmodule

// File: rtl/zcg_checker.sv
module zcg_checker
    import zcg_pkg::*;
#(
    parameter int NCH = 2,
    parameter int CW  = 8,
    parameter int TW  = 14,
    parameter int TO  = 16000
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  zc_en,
    input logic                  cs_n,
    input logic                  mute_eff,
    input logic [NCH*CW-1:0]     gain_code,
    input logic [NCH-1:0][1:0]   st_vec,
    input logic [NCH-1:0][TW-1:0] tmr_vec,
    input logic [NCH-1:0]        tclr_vec
);
    // R7
    mute_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cs_n) |-> $stable(mute_eff));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R3
        timeout_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_vec[c] == S_PEND && !tclr_vec[c] && tmr_vec[c] == TW'(TO - 1))
            |=> st_vec[c] == S_APPLY);
        // R10
        gain_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gain_code[c*CW +: CW] != $past(gain_code[c*CW +: CW]))
            |-> $past(st_vec[c]) == S_APPLY);
        // R1
        idle_nopend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_vec[c] == S_IDLE && !zc_en && !mute_eff) |=> st_vec[c] != S_PEND);
        // R6
        mute_nobypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_vec[c] == S_IDLE && mute_eff) |=> st_vec[c] != S_APPLY);
    end
endmodule

bind zc_gain_updater zcg_checker #(
    .NCH (NCH),
    .CW  (CODE_W),
    .TW  (TMR_W),
    .TO  (TO_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .zc_en     (zc_en),
    .cs_n      (cs_n),
    .mute_eff  (mute_eff),
    .gain_code (gain_code),
    .st_vec    (st_vec),
    .tmr_vec   (tmr_vec),
    .tclr_vec  (tclr_vec)
);

// File: tb/tb_zc_gain_updater.sv
module tb_zc_gain_updater;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int CW  = 8;
    localparam int HZ  = 64_000;
    localparam int TO  = (HZ / 1000) * 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH*CW-1:0] req_code = '0;
    logic [NCH-1:0] req_stb = '0, zc_evt = '0;
    logic zc_en = 1'b0, mute_n = 1'b1, cs_n = 1'b1;
    logic [NCH*CW-1:0] gain_code;
    logic [NCH-1:0] muted;
    int checks = 0, errors = 0;
    logic [CW-1:0] cur [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    zc_gain_updater #(.NCH(NCH), .CODE_W(CW), .CLK_HZ(HZ), .TIMEOUT_MS(16)) dut (
        .clk(clk), .rst_n(rst_n), .req_code(req_code), .req_stb(req_stb),
        .zc_evt(zc_evt), .zc_en(zc_en), .mute_n(mute_n), .cs_n(cs_n),
        .gain_code(gain_code), .muted(muted));

    function automatic int g(input int ch);
        return int'(gain_code[ch*CW +: CW]);
    endfunction

    // Expected code after k crossings while gated.
    function automatic int exp_after(input int k, input int old_c, input int new_c);
        return (k >= 2) ? new_c : old_c;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input int ch, input int code);
        @(negedge clk);
        req_code[ch*CW +: CW] = CW'(code);
        req_stb[ch] = 1'b1;
        @(negedge clk);
        req_stb[ch] = 1'b0;
    endtask

    task automatic zc(input int ch);
        @(negedge clk);
        zc_evt[ch] = 1'b1;
        @(negedge clk);
        zc_evt[ch] = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd5150));
        waitn(3);
        // R8 reset state
        chk("R8 reset g0", g(0), 0);
        chk("R8 reset g1", g(1), 0);
        chk("R8 reset muted", int'(muted), 3);
        rst_n = 1'b1;
        waitn(2);

        // R1 immediate update, R8 independence
        zc_en = 1'b0;
        send(0, 8'h80);
        waitn(2);
        chk("R1 immediate", g(0), 8'h80);
        chk("R8 other channel untouched", g(1), 0);
        chk("R5 muted flag clear", int'(muted[0]), 0);

        // R2 two crossings
        zc_en = 1'b1;
        send(0, 8'h40);
        waitn(5);
        chk("R2 held before crossings", g(0), 8'h80);
        zc(1);
        zc(0);
        waitn(3);
        chk("R2 held after one crossing", g(0), 8'h80);
        zc(0);
        waitn(3);
        chk("R2 applied after two", g(0), 8'h40);

        // R3 timeout
        send(1, 8'hC0);
        waitn(TO - 20);
        chk("R3 before timeout", g(1), 0);
        waitn(40);
        chk("R3 after timeout", g(1), 8'hC0);

        // R4 restart of timeout
        send(0, 8'h10);
        waitn(TO - 100);
        send(0, 8'h20);
        waitn(200);
        chk("R4 timeout restarted", g(0), 8'h40);
        waitn(TO);
        chk("R4 newer code applied", g(0), 8'h20);
        // R4 crossing count cleared
        send(0, 8'h30);
        waitn(4);
        zc(0);
        waitn(3);
        send(0, 8'h31);
        waitn(4);
        zc(0);
        waitn(3);
        chk("R4 crossings cleared", g(0), 8'h20);
        zc(0);
        waitn(3);
        chk("R4 applied after two fresh", g(0), 8'h31);

        // R5 code zero mutes
        zc_en = 1'b0;
        send(1, 8'h00);
        waitn(3);
        chk("R5 zero code", g(1), 0);
        chk("R5 muted flag", int'(muted[1]), 1);
        send(1, 8'h55);
        waitn(3);
        chk("R5 unmuted", g(1), 8'h55);

        // R6 mute pin with one crossing or timeout
        mute_n = 1'b0;
        waitn(5);
        chk("R6 waits for crossing", g(0), 8'h31);
        zc(0);
        waitn(3);
        chk("R6 ch0 muted", int'(muted[0]), 1);
        chk("R6 ch1 not yet", g(1), 8'h55);
        waitn(TO + 10);
        chk("R6 ch1 muted by timeout", int'(muted[1]), 1);

        // R9 release
        mute_n = 1'b1;
        waitn(5);
        chk("R9 ch0 restored", g(0), 8'h31);
        chk("R9 ch1 restored", g(1), 8'h55);

        // R7 deferral during transfer
        cs_n = 1'b0;
        waitn(2);
        mute_n = 1'b0;
        waitn(20);
        zc(0);
        zc(1);
        waitn(TO + 10);
        chk("R7 deferred ch0", g(0), 8'h31);
        chk("R7 deferred ch1", g(1), 8'h55);
        cs_n = 1'b1;
        waitn(3);
        zc(0);
        zc(1);
        waitn(3);
        chk("R7 mute after release of cs", int'(muted), 3);
        mute_n = 1'b1;
        waitn(5);
        chk("R9 restored after deferred mute", g(0), 8'h31);

        // Random phase: R1 R2 R3
        cur[0] = 8'h31;
        cur[1] = 8'h55;
        for (int it = 0; it < 40; it++) begin
            int ch, code, en, k;
            ch = int'($urandom % 2);
            code = int'($urandom % 255) + 1;
            en = int'($urandom % 2);
            zc_en = en[0];
            send(ch, code);
            if (en == 0) begin
                waitn(3);
                chk("R1 random immediate", g(ch), code);
            end else begin
                k = int'($urandom % 4);
                waitn(4);
                for (int i = 0; i < k; i++) begin
                    zc(ch);
                    waitn(3);
                end
                chk("R2 random crossings", g(ch), exp_after(k, int'(cur[ch]), code));
                waitn(TO + 5);
                chk("R3 random timeout", g(ch), code);
            end
            cur[ch] = CW'(code);
            chk("R5 random muted flag", int'(muted[ch]), 0);
        end
        finish_run();
    end
endmodule